// File: doc/BRIEF.md
# Escalating Overdue Watch Timer

This block times a fixed scanning interval from a free-running system clock and raises an alert on a 16-bit LED bank. The alert grows stronger as the deadline approaches and then passes. A pair of active-low pushbuttons controls it. One button returns the block to an idle, cleared condition. The other button starts the interval, or starts it again from zero. The block also produces three 4-bit BCD digits of elapsed time: minutes, tens of seconds and units of seconds. These digits go to an external display decoder.

The controller has five states:
- `ST_IDLE`: cleared and waiting.
- `ST_RUN`: interval in progress.
- `ST_WARN`: the deadline is near.
- `ST_OVER`: the deadline has just passed.
- `ST_LATE`: well past the deadline.

The transitions are:
- reset to `ST_IDLE`, from any state.
- start to `ST_RUN`, from any state.
- `ST_RUN` to `ST_WARN` after `WARN_SEC` seconds.
- `ST_WARN` to `ST_OVER` after `OVER_SEC` more seconds.
- `ST_OVER` to `ST_LATE` after `LATE_SEC` more seconds.

`ST_LATE` holds until one of the buttons is pressed. A single shared segment counter measures each stay. It restarts at zero on every state change.

`CLK_HZ` sets all thresholds in clock cycles. A simulation can use a very small value, so the intervals are short. The buttons are assumed to be synchronous to `clk` and already free of bounce.

Top module: `overdue_watch`

## Requirements
- R1: While `rst_btn_n` is low, the block enters `ST_IDLE` on the next edge, and this overrides `start_btn_n`. In `ST_IDLE` the LEDs are all off and all three digits read 0, and nothing counts.
- R2: With `rst_btn_n` high and `start_btn_n` low, the block enters `ST_RUN` from any state and the digits clear to 0. While start is held, the block stays in `ST_RUN` at time zero.
- R3: After start is released, `ST_RUN` lasts exactly `WARN_SEC*CLK_HZ` clock cycles before the block enters `ST_WARN`.
- R4: `ST_WARN` lasts exactly `OVER_SEC*CLK_HZ` cycles before `ST_OVER`. `ST_OVER` lasts exactly `LATE_SEC*CLK_HZ` cycles before `ST_LATE`. `ST_LATE` holds until a button is pressed.
- R5: In `ST_IDLE` and `ST_RUN`, `led` is 16'h0000.
- R6: In `ST_WARN`, `led[0]` follows the blink flag and `led[15:1]` are 0.
- R7: In `ST_OVER`, `led[3:0]` all follow the blink flag and `led[15:4]` are 0.
- R8: In `ST_LATE`, all 16 LEDs follow the blink flag.
- R9: The blink flag is 1 (lit) in the first cycle of every state. It then toggles every `CLK_HZ` cycles.
- R10: Outside `ST_IDLE`, the elapsed seconds advance by one every `CLK_HZ` cycles. The count is measured from the last start or reset. `sec_ones` is 0 to 9 and `sec_tens` is 0 to 5, both in BCD.
- R11: Seconds wrap from 59 to 00 and carry into `min_ones`. `min_ones` saturates at 9 while the seconds keep wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, `CLK_HZ` cycles per second |
| rst_btn_n | input | 1 | Active-low return to idle, highest priority |
| start_btn_n | input | 1 | Active-low start / restart of the interval |
| led | output | 16 | Alert LED bank |
| sec_ones | output | 4 | Elapsed seconds, units digit (BCD) |
| sec_tens | output | 4 | Elapsed seconds, tens digit (BCD) |
| min_ones | output | 4 | Elapsed minutes, single digit, saturating at 9 |

## Verification
Several button patterns are tried:
- An undisturbed run through all five states.
- A restart issued from `ST_LATE` and another from `ST_WARN`.
- Both buttons pressed together.

The undisturbed run pins the exact length of each segment and the three LED shapes. The restarts show that the shared counter and the blink phase really clear on entry. The simultaneous press tells the reset priority apart from the start priority, because only the idle state leaves the digits frozen afterwards. A long final run goes past nine minutes and separates the seconds wrap from the minute saturation.

// File: rtl/owt_pkg.sv
package owt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_RUN  = 3'd1,
        ST_WARN = 3'd2,
        ST_OVER = 3'd3,
        ST_LATE = 3'd4
    } owt_state_e;

    localparam int unsigned LED_N = 16;

endpackage

// File: rtl/owt_seg_timer.sv
module owt_seg_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (clr) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/owt_blink.sv
module owt_blink #(
    parameter int unsigned HALF_CYC = 4
) (
    input  logic clk,
    input  logic clr,
    output logic blink
);

    localparam int unsigned DIV_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_CYC - 1);

    logic [DIV_W-1:0] div_q;

    always_ff @(posedge clk) begin
        if (clr) begin
            div_q <= '0;
            blink <= 1'b1;
        end else if (div_q == DIV_LAST) begin
            div_q <= '0;
            blink <= ~blink;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

endmodule

// File: rtl/owt_elapsed.sv
module owt_elapsed #(
    parameter int unsigned TICK_CYC = 4
) (
    input  logic       clk,
    input  logic       clr,
    input  logic       run,
    output logic [3:0] sec_ones,
    output logic [3:0] sec_tens,
    output logic [3:0] min_ones
);

    localparam int unsigned TICK_W = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;
    localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(TICK_CYC - 1);

    logic [TICK_W-1:0] tick_q;
    logic              sec_step;
    logic              ones_wrap;
    logic              tens_wrap;

    assign sec_step  = run && (tick_q == TICK_LAST);
    assign ones_wrap = (sec_ones == 4'd9);
    assign tens_wrap = ones_wrap && (sec_tens == 4'd5);

    always_ff @(posedge clk) begin
        if (clr) begin
            tick_q <= '0;
        end else if (run) begin
            tick_q <= sec_step ? '0 : tick_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            sec_ones <= 4'd0;
            sec_tens <= 4'd0;
            min_ones <= 4'd0;
        end else if (sec_step) begin
            sec_ones <= ones_wrap ? 4'd0 : sec_ones + 4'd1;
            if (tens_wrap) begin
                sec_tens <= 4'd0;
                if (min_ones != 4'd9) begin
                    min_ones <= min_ones + 4'd1;
                end
            end else if (ones_wrap) begin
                sec_tens <= sec_tens + 4'd1;
            end
        end
    end

endmodule

// File: rtl/overdue_watch.sv
module overdue_watch
    import owt_pkg::*;
#(
    parameter int unsigned CLK_HZ   = 50_000_000,
    parameter int unsigned WARN_SEC = 110,
    parameter int unsigned OVER_SEC = 10,
    parameter int unsigned LATE_SEC = 5
) (
    input  logic              clk,
    input  logic              rst_btn_n,
    input  logic              start_btn_n,
    output logic [LED_N-1:0]  led,
    output logic [3:0]        sec_ones,
    output logic [3:0]        sec_tens,
    output logic [3:0]        min_ones
);

    localparam longint unsigned WARN_CYC = longint'(CLK_HZ) * longint'(WARN_SEC);
    localparam longint unsigned OVER_CYC = longint'(CLK_HZ) * longint'(OVER_SEC);
    localparam longint unsigned LATE_CYC = longint'(CLK_HZ) * longint'(LATE_SEC);
    localparam longint unsigned MAX_A    = (WARN_CYC > OVER_CYC) ? WARN_CYC : OVER_CYC;
    localparam longint unsigned MAX_CYC  = (MAX_A > LATE_CYC) ? MAX_A : LATE_CYC;
    localparam int unsigned     CNT_W    = $clog2(MAX_CYC) + 1;

    localparam logic [CNT_W-1:0] WARN_LAST = CNT_W'(WARN_CYC - 1);
    localparam logic [CNT_W-1:0] OVER_LAST = CNT_W'(OVER_CYC - 1);
    localparam logic [CNT_W-1:0] LATE_LAST = CNT_W'(LATE_CYC - 1);

    owt_state_e       state;
    owt_state_e       nxt;
    logic [CNT_W-1:0] seg_cnt;
    logic             seg_clr;
    logic             blink;
    logic             time_clr;
    logic             time_run;

    // next-state decision: reset, then start, then segment expiry
    always_comb begin
        nxt = state;
        if (!rst_btn_n) begin
            nxt = ST_IDLE;
        end else if (!start_btn_n) begin
            nxt = ST_RUN;
        end else begin
            unique case (state)
                ST_IDLE: nxt = ST_IDLE;
                ST_RUN:  if (seg_cnt == WARN_LAST) nxt = ST_WARN;
                ST_WARN: if (seg_cnt == OVER_LAST) nxt = ST_OVER;
                ST_OVER: if (seg_cnt == LATE_LAST) nxt = ST_LATE;
                ST_LATE: nxt = ST_LATE;
                default: nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        state <= nxt;
    end

    // every entry (including re-entry by start) restarts the segment
    assign seg_clr  = (nxt != state) || (nxt == ST_IDLE) || !start_btn_n;
    assign time_clr = !rst_btn_n || !start_btn_n;
    assign time_run = (state != ST_IDLE);

    owt_seg_timer #(
        .CNT_W (CNT_W)
    ) u_seg_timer (
        .clk (clk),
        .clr (seg_clr),
        .cnt (seg_cnt)
    );

    owt_blink #(
        .HALF_CYC (CLK_HZ)
    ) u_blink (
        .clk   (clk),
        .clr   (seg_clr),
        .blink (blink)
    );

    owt_elapsed #(
        .TICK_CYC (CLK_HZ)
    ) u_elapsed (
        .clk      (clk),
        .clr      (time_clr),
        .run      (time_run),
        .sec_ones (sec_ones),
        .sec_tens (sec_tens),
        .min_ones (min_ones)
    );

    // LED pattern by state
    always_comb begin
        led = '0;
        unique case (state)
            ST_IDLE: led = '0;
            ST_RUN:  led = '0;
            ST_WARN: led[0] = blink;
            ST_OVER: led[3:0] = {4{blink}};
            ST_LATE: led = {LED_N{blink}};
            default: led = '0;
        endcase
    end

endmodule

// File: rtl/owt_checker.sv
module owt_checker (
    input logic        clk,
    input logic        rst_btn_n,
    input logic        start_btn_n,
    input logic [15:0] led,
    input logic [3:0]  sec_ones,
    input logic [3:0]  sec_tens,
    input logic [3:0]  min_ones
);

    logic armed = 1'b0;

    always_ff @(posedge clk) begin
        if (!rst_btn_n) begin
            armed <= 1'b1;
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!armed)
        !rst_btn_n |=> (led == 16'h0000) && (sec_ones == 4'd0) && (sec_tens == 4'd0) && (min_ones == 4'd0)); // R1

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!armed)
        (rst_btn_n && !start_btn_n) |=> (led == 16'h0000) && (sec_ones == 4'd0) && (sec_tens == 4'd0) && (min_ones == 4'd0)); // R2

    AST_OVER_SHAPE: assert property (@(posedge clk) disable iff (!armed)
        (led[3:1] != 3'd0) |-> (led[3:0] == 4'hF)); // R7

    AST_LATE_SHAPE: assert property (@(posedge clk) disable iff (!armed)
        (led[15:4] != 12'd0) |-> (led == 16'hFFFF)); // R8

    AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (!armed)
        (sec_ones <= 4'd9) && (sec_tens <= 4'd5) && (min_ones <= 4'd9)); // R10

    AST_MIN_SATURATE: assert property (@(posedge clk) disable iff (!armed)
        (min_ones == 4'd9 && rst_btn_n && start_btn_n) |=> (min_ones == 4'd9)); // R11

endmodule

bind overdue_watch owt_checker u_owt_checker (
    .clk         (clk),
    .rst_btn_n   (rst_btn_n),
    .start_btn_n (start_btn_n),
    .led         (led),
    .sec_ones    (sec_ones),
    .sec_tens    (sec_tens),
    .min_ones    (min_ones)
);

// File: tb/overdue_watch_bench.sv
module overdue_watch_bench;

    localparam int HZ       = 4;
    localparam int WARN_CYC = HZ * 110;
    localparam int OVER_CYC = HZ * 10;
    localparam int LATE_CYC = HZ * 5;

    logic        clk = 1'b0;
    logic        rst_btn_n = 1'b1;
    logic        start_btn_n = 1'b1;
    logic [15:0] led;
    logic [3:0]  sec_ones;
    logic [3:0]  sec_tens;
    logic [3:0]  min_ones;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    overdue_watch #(.CLK_HZ(HZ)) u_overdue_watch (
        .clk         (clk),
        .rst_btn_n   (rst_btn_n),
        .start_btn_n (start_btn_n),
        .led         (led),
        .sec_ones    (sec_ones),
        .sec_tens    (sec_tens),
        .min_ones    (min_ones)
    );

    // behavioural reference: 0 idle, 1 run, 2 warn, 3 over, 4 late
    int  m_st = 0;
    int  m_cnt = 0;
    int  m_bdiv = 0;
    bit  m_blk = 1'b1;
    int  m_tick = 0;
    int  m_secs = 0;
    int  m_min = 0;
    bit  m_valid = 1'b0;

    always @(posedge clk) begin
        int n;
        bit restart;
        n = m_st;
        if (!rst_btn_n) n = 0;
        else if (!start_btn_n) n = 1;
        else if (m_st == 1 && m_cnt == WARN_CYC - 1) n = 2;
        else if (m_st == 2 && m_cnt == OVER_CYC - 1) n = 3;
        else if (m_st == 3 && m_cnt == LATE_CYC - 1) n = 4;
        restart = (n != m_st) || (n == 0) || !start_btn_n;
        if (restart) begin
            m_cnt = 0; m_bdiv = 0; m_blk = 1'b1;
        end else begin
            m_cnt++;
            if (m_bdiv == HZ - 1) begin m_bdiv = 0; m_blk = !m_blk; end
            else m_bdiv++;
        end
        if (!rst_btn_n || !start_btn_n) begin
            m_tick = 0; m_secs = 0; m_min = 0;
        end else if (m_st != 0) begin
            m_tick++;
            if (m_tick == HZ) begin
                m_tick = 0;
                m_secs++;
                if (m_secs == 60) begin
                    m_secs = 0;
                    if (m_min < 9) m_min++;
                end
            end
        end
        m_st = n;
        if (!rst_btn_n) m_valid = 1'b1;
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (m_valid) begin
            logic [15:0] e_led;
            string tag;
            case (m_st)
                2:       begin e_led = {15'd0, m_blk}; tag = "R6 warn leds"; end
                3:       begin e_led = {12'd0, {4{m_blk}}}; tag = "R7 over leds"; end
                4:       begin e_led = {16{m_blk}}; tag = "R8 late leds"; end
                default: begin e_led = 16'd0; tag = "R5 idle/run leds"; end
            endcase
            check(led === e_led, tag, led, e_led);
            check(sec_ones === 4'(m_secs % 10) && sec_tens === 4'(m_secs / 10),
                  "R10 seconds", {sec_tens, sec_ones}, ((m_secs / 10) << 4) | (m_secs % 10));
            check(min_ones === 4'(m_min), "R11 minutes", min_ones, m_min);
        end
    end

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        int n;
        int lit;
        @(negedge clk);
        rst_btn_n = 1'b0;
        cycles(3);
        check(led === 16'd0 && sec_ones === 4'd0 && min_ones === 4'd0, "R1 reset state", led, 0);
        rst_btn_n = 1'b1;
        cycles(10);
        // both pressed: reset must win, so digits stay frozen afterwards
        rst_btn_n = 1'b0; start_btn_n = 1'b0;
        cycles(2);
        rst_btn_n = 1'b1; start_btn_n = 1'b1;
        cycles(20);
        check(sec_ones === 4'd0, "R1 priority over start", sec_ones, 0);

        // clean run through all states
        start_btn_n = 1'b0;
        cycles(3);
        check(led === 16'd0 && sec_ones === 4'd0, "R2 start held", sec_ones, 0);
        start_btn_n = 1'b1;
        n = 0;
        do begin @(negedge clk); n++; end while (led === 16'd0 && n < 2000);
        check(n == WARN_CYC, "R3 run length", n, WARN_CYC);
        lit = 0;
        while (led[0] === 1'b1 && lit < 2000) begin lit++; @(negedge clk); end
        check(lit == HZ, "R9 first lit phase", lit, HZ);
        n = lit;
        while (led[3:1] === 3'd0 && n < 2000) begin n++; @(negedge clk); end
        check(n == OVER_CYC, "R4 warn length", n, OVER_CYC);
        n = 0;
        while (led[15:4] === 12'd0 && n < 2000) begin n++; @(negedge clk); end
        check(n == LATE_CYC, "R4 over length", n, LATE_CYC);
        cycles(100);

        // restart from LATE, then again from WARN
        start_btn_n = 1'b0;
        cycles(1);
        start_btn_n = 1'b1;
        cycles(WARN_CYC + 20);
        start_btn_n = 1'b0;
        cycles(1);
        check(led === 16'd0, "R2 restart from warn", led, 0);
        start_btn_n = 1'b1;
        cycles(300);

        // long run past nine minutes
        rst_btn_n = 1'b0;
        cycles(2);
        rst_btn_n = 1'b1;
        start_btn_n = 1'b0;
        cycles(1);
        start_btn_n = 1'b1;
        cycles(HZ * 60 * 10 + 50);
        check(min_ones === 4'd9, "R11 minute saturation", min_ones, 9);
        finish_run();
    end

endmodule